// File: doc/BRIEF.md
# Command Set Sequencer with Interrupts

The block keeps several independent command sets. Each set owns a parameterised number of command slots (at most sixteen), and each slot stores a message identifier, a target address and a data word. A processor-side register port loads the slots, chooses which slots take part through a per-set enable mask, marks the slots that must wait for an answer, and fires the set through a two-bit control register. Firing takes a fixed handshake: clear trigger, clear mode-enable, set mode-enable, then set trigger.

Once a set has fired, its enabled slots go out one at a time on a valid/ready command port. A response port carries back the set and slot of every command that has been answered. The block records per-slot issued and answered flags. It declares the set idle when every enabled slot is complete. It then raises that set's interrupt status bit if the set's interrupt is enabled, and software clears the bit by writing a one.

Top module: `cmdset_seq`

## Requirements
- R1: Register map, byte addresses. Shared registers: interrupt enable 0x00, interrupt status 0x04, interrupt clear 0x08 (one bit per set, bit s = set s). Set s starts at s*672 and holds wait mask +0x10, control +0x14, state +0x18 and slot enable mask +0x1C (bit k = slot k). Slot k of set s starts at s*672+0x30+20*k and holds message id +0x0, address +0x4, data +0x8 and a read-only slot status word +0xC. Read data appears on `reg_rdata` one clock after the address is presented.
- R2: Control bit 0 is mode-enable and bit 1 is trigger. A set starts only on a write that has both bits at one while the held control value has mode-enable at one and trigger at zero. Any other control write only stores the two bits.
- R3: A started set presents its enabled slots in ascending slot order, one command at a time. A presented command stays stable until `cmd_ready` accepts it. When several sets have commands waiting, the lowest set index goes next.
- R4: Slot status bit 8 is set when the command has been accepted, and bit 16 is set when its response has arrived. A start clears both bits for every slot of that set.
- R5: A command needs a response when its wait-mask bit is one or when bit 8 of its message id is one. Any other command is complete as soon as it is accepted.
- R6: The set state register reads 1 while the set is idle and 0 while it is busy. The set returns to idle the cycle after its last enabled command becomes complete.
- R7: When a set returns to idle, its interrupt status bit is set only if its interrupt enable bit is one. `irq` is the OR over sets of status AND enable, registered, so it follows one clock later.
- R8: Writing the clear register clears every status bit written as one and leaves the bits written as zero unchanged. The clear register reads as zero.
- R9: While a set is busy, writes to its wait mask, its enable mask and its slot fields are ignored.
- R10: A response for a slot that has not been accepted, or for a set that is idle, changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Registered read data for the previous cycle's address |
| cmd_valid | output | 1 | Command presented |
| cmd_ready | input | 1 | Command accepted by the remote side |
| cmd_set | output | SET_W | Set index of the presented command |
| cmd_slot | output | SLOT_W | Slot index of the presented command |
| cmd_msgid | output | DATA_W | Message id of the presented command |
| cmd_addr | output | DATA_W | Address of the presented command |
| cmd_data | output | DATA_W | Data of the presented command |
| rsp_valid | input | 1 | Response strobe |
| rsp_set | input | SET_W | Set index of the answered command |
| rsp_slot | input | SLOT_W | Slot index of the answered command |
| irq | output | 1 | Combined interrupt |

## Verification
The bench builds the block with three sets of five slots each. With five slots, the highest present slot and a partly filled enable mask are both tested. With three sets, two sets can compete for the command port while a third is left with its interrupt disabled. The remote side throttles or stalls `cmd_ready` and can hold back responses. This stretches a busy window far enough to test ignored writes, set priority, responses that arrive before issue, and sets that wait on their completions.

// File: rtl/cs_pkg.sv
package cs_pkg;
  localparam int SET_STRIDE  = 672;
  localparam int SLOT_BASE   = 'h30;
  localparam int SLOT_STRIDE = 20;
  localparam int OFS_IEN     = 'h00;
  localparam int OFS_ISTAT   = 'h04;
  localparam int OFS_ICLR    = 'h08;
  localparam int OFS_WAIT    = 'h10;
  localparam int OFS_CTRL    = 'h14;
  localparam int OFS_STATE   = 'h18;
  localparam int OFS_CEN     = 'h1C;
  localparam int FLD_MID     = 'h0;
  localparam int FLD_ADDR    = 'h4;
  localparam int FLD_DATA    = 'h8;
  localparam int FLD_CST     = 'hC;
  localparam int CTRL_EN_BIT   = 0;
  localparam int CTRL_TRIG_BIT = 1;
  localparam int ST_ISSUED_BIT = 8;
  localparam int ST_ANSWER_BIT = 16;

  typedef enum logic [3:0] {
    K_NONE, K_IEN, K_ISTAT, K_ICLR, K_WAIT, K_CTRL, K_STATE, K_CEN,
    K_MID, K_ADDR, K_DATA, K_CST
  } reg_kind_e;
endpackage

// File: rtl/cs_regdec.sv
module cs_regdec
  import cs_pkg::*;
#(
  parameter int NUM_SETS  = 4,
  parameter int NUM_SLOTS = 16,
  parameter int ADDR_W    = 12,
  parameter int SET_W     = 2,
  parameter int SLOT_W    = 4
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_kind_e         kind,
  output logic [SET_W-1:0]  set_idx,
  output logic [SLOT_W-1:0] slot_idx
);
  int a;
  always_comb begin
    a        = int'(addr);
    kind     = K_NONE;
    set_idx  = '0;
    slot_idx = '0;
    if (a == OFS_IEN)   kind = K_IEN;
    if (a == OFS_ISTAT) kind = K_ISTAT;
    if (a == OFS_ICLR)  kind = K_ICLR;
    for (int s = 0; s < NUM_SETS; s++) begin
      if (a == s*SET_STRIDE + OFS_WAIT)  begin kind = K_WAIT;  set_idx = SET_W'(s); end
      if (a == s*SET_STRIDE + OFS_CTRL)  begin kind = K_CTRL;  set_idx = SET_W'(s); end
      if (a == s*SET_STRIDE + OFS_STATE) begin kind = K_STATE; set_idx = SET_W'(s); end
      if (a == s*SET_STRIDE + OFS_CEN)   begin kind = K_CEN;   set_idx = SET_W'(s); end
      for (int k = 0; k < NUM_SLOTS; k++) begin
        if (a == s*SET_STRIDE + SLOT_BASE + k*SLOT_STRIDE + FLD_MID) begin
          kind = K_MID; set_idx = SET_W'(s); slot_idx = SLOT_W'(k);
        end
        if (a == s*SET_STRIDE + SLOT_BASE + k*SLOT_STRIDE + FLD_ADDR) begin
          kind = K_ADDR; set_idx = SET_W'(s); slot_idx = SLOT_W'(k);
        end
        if (a == s*SET_STRIDE + SLOT_BASE + k*SLOT_STRIDE + FLD_DATA) begin
          kind = K_DATA; set_idx = SET_W'(s); slot_idx = SLOT_W'(k);
        end
        if (a == s*SET_STRIDE + SLOT_BASE + k*SLOT_STRIDE + FLD_CST) begin
          kind = K_CST; set_idx = SET_W'(s); slot_idx = SLOT_W'(k);
        end
      end
    end
  end
endmodule

// File: rtl/cs_issue.sv
module cs_issue #(
  parameter int NUM_SETS  = 4,
  parameter int NUM_SLOTS = 16,
  parameter int SET_W     = 2,
  parameter int SLOT_W    = 4
) (
  input  logic [NUM_SETS-1:0][NUM_SLOTS-1:0] pend,
  output logic                               pick_valid,
  output logic [SET_W-1:0]                   pick_set,
  output logic [SLOT_W-1:0]                  pick_slot
);
  // Fixed priority: lowest set first, then lowest slot within that set.
  always_comb begin
    pick_valid = 1'b0;
    pick_set   = '0;
    pick_slot  = '0;
    for (int s = 0; s < NUM_SETS; s++) begin
      for (int k = 0; k < NUM_SLOTS; k++) begin
        if (!pick_valid && pend[s][k]) begin
          pick_valid = 1'b1;
          pick_set   = SET_W'(s);
          pick_slot  = SLOT_W'(k);
        end
      end
    end
  end
endmodule

// File: rtl/cs_irq.sv
module cs_irq #(
  parameter int NUM_SETS = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ien_we,
  input  logic                clr_we,
  input  logic [NUM_SETS-1:0] wbits,
  input  logic [NUM_SETS-1:0] done,
  output logic [NUM_SETS-1:0] ien,
  output logic [NUM_SETS-1:0] istat,
  output logic                irq
);
  logic [NUM_SETS-1:0] clr_mask;
  assign clr_mask = clr_we ? wbits : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      ien   <= '0;
      istat <= '0;
      irq   <= 1'b0;
    end else begin
      if (ien_we) ien <= wbits;
      // A new completion wins over a clear in the same cycle.
      istat <= (istat & ~clr_mask) | (done & ien);
      irq   <= |(istat & ien);
    end
  end

  // R7: a status bit only rises after a finishing set whose interrupt was enabled
  assert_irq_gate_R7: assert property (@(posedge clk) disable iff (rst)
    (istat & ~$past(istat) & ~$past(done & ien)) == '0);
endmodule

// File: rtl/cmdset_seq.sv
module cmdset_seq
  import cs_pkg::*;
#(
  parameter int NUM_SETS  = 4,
  parameter int NUM_SLOTS = 16,
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 32,
  parameter int RESP_BIT  = 8,
  localparam int SET_W    = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1,
  localparam int SLOT_W   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [SET_W-1:0]  cmd_set,
  output logic [SLOT_W-1:0] cmd_slot,
  output logic [DATA_W-1:0] cmd_msgid,
  output logic [DATA_W-1:0] cmd_addr,
  output logic [DATA_W-1:0] cmd_data,
  input  logic              rsp_valid,
  input  logic [SET_W-1:0]  rsp_set,
  input  logic [SLOT_W-1:0] rsp_slot,
  output logic              irq
);
  localparam int TOT   = NUM_SETS * NUM_SLOTS;
  localparam int IDX_W = $clog2(TOT) + 1;

  // Per-set state
  logic [NUM_SETS-1:0][NUM_SLOTS-1:0] wait_q, cen_q, iss_q, ans_q, fin_q, pend;
  logic [NUM_SETS-1:0] men_q, trg_q, busy_q, done;
  logic [NUM_SETS-1:0] ien, istat;

  // Slot storage, one entry per (set, slot), no reset so it can map to RAM
  logic [DATA_W-1:0] mid_mem [TOT];
  logic [DATA_W-1:0] adr_mem [TOT];
  logic [DATA_W-1:0] dat_mem [TOT];

  reg_kind_e         kind;
  logic [SET_W-1:0]  dset;
  logic [SLOT_W-1:0] dslot;
  logic [IDX_W-1:0]  widx, pidx;
  logic              wr_open;

  cs_regdec #(.NUM_SETS(NUM_SETS), .NUM_SLOTS(NUM_SLOTS), .ADDR_W(ADDR_W),
              .SET_W(SET_W), .SLOT_W(SLOT_W)) i_dec (
    .addr(reg_addr), .kind(kind), .set_idx(dset), .slot_idx(dslot));

  assign widx    = IDX_W'(dset) * IDX_W'(NUM_SLOTS) + IDX_W'(dslot);
  assign wr_open = reg_wr && !busy_q[dset];

  always_ff @(posedge clk) begin
    if (wr_open) begin
      case (kind)
        K_MID:   mid_mem[widx] <= reg_wdata;
        K_ADDR:  adr_mem[widx] <= reg_wdata;
        K_DATA:  dat_mem[widx] <= reg_wdata;
        default: ;
      endcase
    end
  end

  // Issue engine
  logic              cv_q, cneed_q, pick_valid, hs;
  logic [SET_W-1:0]  cset_q, pick_set;
  logic [SLOT_W-1:0] cslot_q, pick_slot;
  logic [DATA_W-1:0] cmid_q, cadr_q, cdat_q;

  always_comb begin
    for (int s = 0; s < NUM_SETS; s++) begin
      pend[s] = busy_q[s] ? (cen_q[s] & ~iss_q[s]) : '0;
      done[s] = busy_q[s] && ((cen_q[s] & ~fin_q[s]) == '0);
    end
  end

  cs_issue #(.NUM_SETS(NUM_SETS), .NUM_SLOTS(NUM_SLOTS), .SET_W(SET_W),
             .SLOT_W(SLOT_W)) i_issue (
    .pend(pend), .pick_valid(pick_valid), .pick_set(pick_set), .pick_slot(pick_slot));

  assign pidx = IDX_W'(pick_set) * IDX_W'(NUM_SLOTS) + IDX_W'(pick_slot);
  assign hs   = cv_q && cmd_ready;

  always_ff @(posedge clk) begin
    if (rst)                      cv_q <= 1'b0;
    else if (hs)                  cv_q <= 1'b0;
    else if (!cv_q && pick_valid) cv_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!cv_q && pick_valid) begin
      cset_q  <= pick_set;
      cslot_q <= pick_slot;
      cmid_q  <= mid_mem[pidx];
      cadr_q  <= adr_mem[pidx];
      cdat_q  <= dat_mem[pidx];
      cneed_q <= wait_q[pick_set][pick_slot] | mid_mem[pidx][RESP_BIT];
    end
  end

  assign cmd_valid = cv_q;
  assign cmd_set   = cset_q;
  assign cmd_slot  = cslot_q;
  assign cmd_msgid = cmid_q;
  assign cmd_addr  = cadr_q;
  assign cmd_data  = cdat_q;

  // Control and tracking state
  always_ff @(posedge clk) begin
    if (rst) begin
      wait_q <= '0; cen_q <= '0; iss_q <= '0; ans_q <= '0; fin_q <= '0;
      men_q  <= '0; trg_q <= '0; busy_q <= '0;
    end else begin
      for (int s = 0; s < NUM_SETS; s++) begin
        if (reg_wr && dset == SET_W'(s)) begin
          if (kind == K_CTRL) begin
            men_q[s] <= reg_wdata[CTRL_EN_BIT];
            trg_q[s] <= reg_wdata[CTRL_TRIG_BIT];
          end
          if (kind == K_WAIT && !busy_q[s]) wait_q[s] <= reg_wdata[NUM_SLOTS-1:0];
          if (kind == K_CEN  && !busy_q[s]) cen_q[s]  <= reg_wdata[NUM_SLOTS-1:0];
        end
        if (reg_wr && kind == K_CTRL && dset == SET_W'(s) && !busy_q[s] &&
            men_q[s] && !trg_q[s] && reg_wdata[CTRL_EN_BIT] && reg_wdata[CTRL_TRIG_BIT]) begin
          busy_q[s] <= 1'b1;
          iss_q[s]  <= '0;
          ans_q[s]  <= '0;
          fin_q[s]  <= '0;
        end else if (done[s]) begin
          busy_q[s] <= 1'b0;
        end else begin
          for (int k = 0; k < NUM_SLOTS; k++) begin
            if (hs && cset_q == SET_W'(s) && cslot_q == SLOT_W'(k)) begin
              iss_q[s][k] <= 1'b1;
              if (!cneed_q) fin_q[s][k] <= 1'b1;
            end
            if (rsp_valid && rsp_set == SET_W'(s) && rsp_slot == SLOT_W'(k) &&
                busy_q[s] && iss_q[s][k]) begin
              ans_q[s][k] <= 1'b1;
              fin_q[s][k] <= 1'b1;
            end
          end
        end
      end
    end
  end

  cs_irq #(.NUM_SETS(NUM_SETS)) i_irq (
    .clk(clk), .rst(rst),
    .ien_we(reg_wr && kind == K_IEN),
    .clr_we(reg_wr && kind == K_ICLR),
    .wbits(reg_wdata[NUM_SETS-1:0]),
    .done(done), .ien(ien), .istat(istat), .irq(irq));

  // Registered read mux
  logic [DATA_W-1:0] rd_val;
  always_comb begin
    rd_val = '0;
    case (kind)
      K_IEN:   rd_val = DATA_W'(ien);
      K_ISTAT: rd_val = DATA_W'(istat);
      K_WAIT:  rd_val = DATA_W'(wait_q[dset]);
      K_CEN:   rd_val = DATA_W'(cen_q[dset]);
      K_CTRL:  begin
        rd_val[CTRL_EN_BIT]   = men_q[dset];
        rd_val[CTRL_TRIG_BIT] = trg_q[dset];
      end
      K_STATE: rd_val[0] = !busy_q[dset];
      K_MID:   rd_val = mid_mem[widx];
      K_ADDR:  rd_val = adr_mem[widx];
      K_DATA:  rd_val = dat_mem[widx];
      K_CST:   begin
        rd_val[ST_ISSUED_BIT] = iss_q[dset][dslot];
        rd_val[ST_ANSWER_BIT] = ans_q[dset][dslot];
      end
      default: rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_val;
  end

  // R3: a presented command holds until it is accepted
  assert_cmd_hold_R3: assert property (@(posedge clk) disable iff (rst)
    cv_q && !cmd_ready |=> cv_q && $stable(cset_q) && $stable(cslot_q) &&
    $stable(cadr_q) && $stable(cdat_q) && $stable(cmid_q));

  // R3: commands only come from a busy set
  assert_cmd_busy_R3: assert property (@(posedge clk) disable iff (rst)
    cv_q |-> busy_q[cset_q]);

  for (genvar g = 0; g < NUM_SETS; g++) begin : g_chk
    // R2: a set only starts on a register write
    assert_start_write_R2: assert property (@(posedge clk) disable iff (rst)
      $rose(busy_q[g]) |-> $past(reg_wr) && $past(men_q[g]) && !$past(trg_q[g]));
    // R6: a set only goes idle once every enabled slot was issued
    assert_idle_issued_R6: assert property (@(posedge clk) disable iff (rst)
      $fell(busy_q[g]) |-> ($past(cen_q[g]) & ~$past(iss_q[g])) == '0);
    // R9: masks are frozen while a set is busy
    assert_busy_frozen_R9: assert property (@(posedge clk) disable iff (rst)
      busy_q[g] && $past(busy_q[g]) |-> $stable(cen_q[g]) && $stable(wait_q[g]));
  end
endmodule

// File: tb/test_cmdset_seq.sv
`timescale 1ns/1ps
module test_cmdset_seq;
  localparam int NS = 3;
  localparam int NK = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_wr = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic cmd_valid, cmd_ready = 1'b0;
  logic [1:0] cmd_set;
  logic [2:0] cmd_slot;
  logic [31:0] cmd_msgid, cmd_addr, cmd_data;
  logic rsp_valid = 1'b0;
  logic [1:0] rsp_set = '0;
  logic [2:0] rsp_slot = '0;
  logic irq;

  always #4 clk = ~clk;

  cmdset_seq #(.NUM_SETS(NS), .NUM_SLOTS(NK), .ADDR_W(12), .DATA_W(32), .RESP_BIT(8)) i_cmdset_seq (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_set(cmd_set),
    .cmd_slot(cmd_slot), .cmd_msgid(cmd_msgid), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
    .rsp_valid(rsp_valid), .rsp_set(rsp_set), .rsp_slot(rsp_slot), .irq(irq));

  int total = 0;
  int bad = 0;

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Reference model: expected command stream and pending responses
  typedef struct { int s; int k; logic [31:0] mid; logic [31:0] adr; logic [31:0] dat; bit need; } ecmd_t;
  typedef struct { int s; int k; int due; } ersp_t;
  ecmd_t expq[$];
  ersp_t rspq[$];
  ecmd_t e;
  ersp_t r;
  logic [31:0] m_mid [NS][NK];
  logic [31:0] m_adr [NS][NK];
  logic [31:0] m_dat [NS][NK];
  logic [NK-1:0] m_wait [NS];

  bit ready_en = 1'b1, throttle = 1'b0, rsp_hold = 1'b0, inj_go = 1'b0;
  int inj_s = 0, inj_k = 0, cyc = 0;

  // Remote side, compared on every clock
  always @(negedge clk) begin
    cyc++;
    if (rst) begin
      cmd_ready = 1'b0;
      rsp_valid = 1'b0;
    end else begin
      cmd_ready = ready_en && (!throttle || (cyc % 3) != 1);
      if (cmd_valid && expq.size() == 0) chk("R3 command with none expected", 64'd1, 64'd0);
      if (cmd_valid && cmd_ready && expq.size() > 0) begin
        e = expq.pop_front();
        chk("R3 issue order", {27'b0, cmd_set, cmd_slot, cmd_addr}, {27'b0, e.s[1:0], e.k[2:0], e.adr});
        chk("R1 command payload", {cmd_msgid, cmd_data}, {e.mid, e.dat});
        if (e.need) rspq.push_back(ersp_t'{e.s, e.k, cyc + 3});
      end
      if (inj_go) begin
        rsp_valid = 1'b1; rsp_set = inj_s[1:0]; rsp_slot = inj_k[2:0]; inj_go = 1'b0;
      end else if (!rsp_hold && rspq.size() > 0 && rspq[0].due <= cyc) begin
        r = rspq.pop_front();
        rsp_valid = 1'b1; rsp_set = r.s[1:0]; rsp_slot = r.k[2:0];
      end else begin
        rsp_valid = 1'b0;
      end
    end
  end

  function automatic logic [11:0] sa(int s, int ofs);
    return 12'(s*672 + ofs);
  endfunction
  function automatic logic [11:0] ka(int s, int k, int f);
    return 12'(s*672 + 'h30 + 20*k + f);
  endfunction

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask
  task automatic rd(logic [11:0] a, output logic [31:0] d);
    @(negedge clk); reg_wr = 1'b0; reg_addr = a;
    @(negedge clk); d = reg_rdata;
  endtask
  task automatic prog(int s, int k, logic [31:0] mid, logic [31:0] adr, logic [31:0] dat);
    wr(ka(s, k, 0), mid); wr(ka(s, k, 4), adr); wr(ka(s, k, 8), dat);
    m_mid[s][k] = mid; m_adr[s][k] = adr; m_dat[s][k] = dat;
  endtask
  task automatic expect_cmd(int s, int k);
    expq.push_back(ecmd_t'{s, k, m_mid[s][k], m_adr[s][k], m_dat[s][k],
                           m_wait[s][k] | m_mid[s][k][8]});
  endtask
  task automatic fire(int s);
    wr(sa(s, 'h14), 32'h1); wr(sa(s, 'h14), 32'h0);
    wr(sa(s, 'h14), 32'h1); wr(sa(s, 'h14), 32'h3);
  endtask
  task automatic wait_idle(int s, string req);
    logic [31:0] v;
    v = 0;
    for (int i = 0; i < 300 && v != 1; i++) rd(sa(s, 'h18), v);
    chk(req, 64'(v), 64'd1);
  endtask
  task automatic inject(int s, int k);
    inj_s = s; inj_k = k; inj_go = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  logic [31:0] v;

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int s = 0; s < NS; s++) m_wait[s] = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // Reset state
    chk("R7 irq low after reset", 64'(irq), 64'd0);
    chk("R3 no command after reset", 64'(cmd_valid), 64'd0);
    rd(12'h004, v); chk("R7 status clear after reset", 64'(v), 64'd0);
    rd(sa(0, 'h18), v); chk("R6 idle after reset", 64'(v), 64'd1);

    // R1 programming and readback
    wr(12'h000, 32'h3);
    rd(12'h000, v); chk("R1 interrupt enable readback", 64'(v), 64'd3);
    prog(0, 0, 32'h10, 32'hA000, 32'h1111);
    prog(0, 1, 32'h11, 32'hA004, 32'h2222);
    prog(0, 2, 32'h112, 32'hA008, 32'h3333);
    prog(0, 3, 32'h13, 32'hA00C, 32'h4444);
    prog(0, 4, 32'h14, 32'hA010, 32'h5555);
    rd(ka(0, 2, 4), v); chk("R1 slot address readback", 64'(v), 64'hA008);
    rd(ka(0, 4, 8), v); chk("R1 top slot data readback", 64'(v), 64'h5555);
    wr(sa(0, 'h10), 32'h02); m_wait[0] = 5'b00010;
    wr(sa(0, 'h1C), 32'h17);
    rd(sa(0, 'h1C), v); chk("R1 enable mask readback", 64'(v), 64'h17);

    // R3/R4/R5 main run with a throttled remote side
    throttle = 1'b1;
    expect_cmd(0, 0); expect_cmd(0, 1); expect_cmd(0, 2); expect_cmd(0, 4);
    fire(0);
    rd(sa(0, 'h18), v); chk("R6 busy after start", 64'(v), 64'd0);
    wait_idle(0, "R6 set 0 returns idle");
    chk("R3 all commands issued", 64'(expq.size()), 64'd0);
    rd(ka(0, 0, 'hC), v); chk("R4 fire-and-forget slot status", 64'(v), 64'h100);
    rd(ka(0, 1, 'hC), v); chk("R5 wait-mask slot answered", 64'(v), 64'h10100);
    rd(ka(0, 2, 'hC), v); chk("R5 msgid-bit slot answered", 64'(v), 64'h10100);
    rd(ka(0, 3, 'hC), v); chk("R4 disabled slot untouched", 64'(v), 64'h0);
    rd(12'h004, v); chk("R7 status set for enabled set", 64'(v), 64'h1);
    repeat (2) @(negedge clk);
    chk("R7 irq raised", 64'(irq), 64'd1);
    throttle = 1'b0;

    // R8 write-one-to-clear
    wr(12'h008, 32'h0);
    rd(12'h004, v); chk("R8 zero write keeps status", 64'(v), 64'h1);
    rd(12'h008, v); chk("R8 clear register reads zero", 64'(v), 64'h0);
    wr(12'h008, 32'h1);
    rd(12'h004, v); chk("R8 one write clears status", 64'(v), 64'h0);
    repeat (2) @(negedge clk);
    chk("R8 irq dropped after clear", 64'(irq), 64'd0);

    // R7 disabled interrupt on set 2
    prog(2, 0, 32'h20, 32'hC000, 32'h9);
    wr(sa(2, 'h1C), 32'h1);
    expect_cmd(2, 0);
    fire(2);
    wait_idle(2, "R6 set 2 returns idle");
    rd(12'h004, v); chk("R7 no status for disabled set", 64'(v), 64'h0);
    repeat (2) @(negedge clk);
    chk("R7 irq stays low", 64'(irq), 64'd0);

    // R10 response to an idle set
    inject(2, 0);
    rd(ka(2, 0, 'hC), v); chk("R10 idle set ignores response", 64'(v), 64'h100);

    // R2 illegal trigger sequences
    prog(1, 0, 32'h30, 32'hB000, 32'h77);
    prog(1, 1, 32'h31, 32'hB004, 32'h88);
    wr(sa(1, 'h1C), 32'h3);
    wr(sa(1, 'h14), 32'h2);
    wr(sa(1, 'h14), 32'h3);
    repeat (6) @(negedge clk);
    chk("R2 no start without prior enable", 64'(cmd_valid), 64'd0);
    rd(sa(1, 'h18), v); chk("R2 set stays idle", 64'(v), 64'd1);
    rd(sa(1, 'h14), v); chk("R2 control bits stored", 64'(v), 64'd3);

    // R3 set priority and R9 busy-write blocking
    ready_en = 1'b0;
    prog(0, 3, 32'h13, 32'hA00C, 32'h4444);
    wr(sa(0, 'h1C), 32'h09);
    m_wait[0] = 5'b00000; wr(sa(0, 'h10), 32'h0);
    expect_cmd(1, 0); expect_cmd(0, 0); expect_cmd(0, 3); expect_cmd(1, 1);
    fire(1);
    fire(0);
    wr(ka(0, 3, 8), 32'hDEAD);
    wr(sa(0, 'h1C), 32'h1F);
    wr(sa(0, 'h10), 32'h1F);
    rd(sa(0, 'h1C), v); chk("R9 enable mask write ignored while busy", 64'(v), 64'h09);
    rd(sa(0, 'h10), v); chk("R9 wait mask write ignored while busy", 64'(v), 64'h0);
    rd(ka(0, 3, 8), v); chk("R9 slot data write ignored while busy", 64'(v), 64'h4444);
    ready_en = 1'b1;
    wait_idle(1, "R6 set 1 returns idle");
    wait_idle(0, "R6 set 0 returns idle again");
    chk("R3 priority stream consumed", 64'(expq.size()), 64'd0);
    rd(12'h004, v); chk("R7 both enabled sets flagged", 64'(v), 64'h3);
    wr(12'h008, 32'h2);
    rd(12'h004, v); chk("R8 clears only written bit", 64'(v), 64'h1);
    wr(12'h008, 32'h1);

    // R5 completion held back, R10 early response
    prog(2, 0, 32'h120, 32'hC000, 32'h9);
    prog(2, 1, 32'h21, 32'hC004, 32'hA);
    wr(sa(2, 'h10), 32'h2); m_wait[2] = 5'b00010;
    wr(sa(2, 'h1C), 32'h3);
    ready_en = 1'b0; rsp_hold = 1'b1;
    expect_cmd(2, 0); expect_cmd(2, 1);
    fire(2);
    inject(2, 1);
    rd(ka(2, 1, 'hC), v); chk("R10 response before issue ignored", 64'(v), 64'h0);
    ready_en = 1'b1;
    repeat (15) @(negedge clk);
    rd(sa(2, 'h18), v); chk("R5 set waits for completions", 64'(v), 64'd0);
    rd(ka(2, 0, 'hC), v); chk("R5 issued but unanswered", 64'(v), 64'h100);
    rsp_hold = 1'b0;
    wait_idle(2, "R5 set 2 idle after answers");
    rd(ka(2, 1, 'hC), v); chk("R5 answered after release", 64'(v), 64'h10100);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule